// File: doc/BRIEF.md
# Edge-Aligned Multi-Channel PWM Timer

This block is a memory-mapped PWM timer. One up-counter, one power-of-two prescaler and one modulo register are shared by a parameterised set of compare channels. Each channel drives one output pin with an edge-aligned pulse. The pulse opens when the counter reloads and closes when the counter reaches the channel's compare value. Each channel selects its own polarity.

Software uses a plain 32-bit register port. A write is applied on the clock edge where `we_i` is high. A read is combinational on `addr_i`. Modulo and compare writes made while the counter runs are held until the next reload, so a period never ends part-way. The same writes take effect at once while the counter is stopped. Each channel has a sticky match flag, cleared by writing one to it. A centre-aligned select bit is stored and read back but does not change counting.

Top module: `pwm_timer`

## Requirements
- R1: After reset every register reads 0, the counter is stopped and every bit of `pwm_o` is 0.
- R2: Offset 0x04 reads the channel count in bits [7:0]. Offset 0x08 reads 0.
- R3: Offset 0x10 holds the prescale in bits [2:0], the clock mode in bits [4:3] and the centre-aligned select in bit 5. All three read back. The counter runs only with clock mode 01, and then advances once every 2^prescale clocks. Bit 5 has no effect.
- R4: On an advance where the counter is at or above the effective modulo, the counter reloads to 0; otherwise it adds one. A write of any value to offset 0x14 sets the counter to 0. A stopped counter holds its value.
- R5: A write to the modulo register at 0x18 reads back at once. It takes effect at once while the counter is stopped. While the counter runs, it takes effect at the next reload.
- R6: The channel n control register is at 0x20+8n: mode bits [5:4], level bits [3:2]. A channel is on only with mode 10 and level 10 (high-true) or 01 (low-true). Every other setting drives its output to 0.
- R7: After each advance, an enabled channel outputs its pulse level while the counter is below the effective compare value, and the opposite level otherwise. The pulse level is 1 for high-true and 0 for low-true. A compare value of 0 gives a constant non-pulse level. A compare value above the modulo gives a constant pulse level.
- R8: The compare value of channel n is at 0x24+8n. A write reads back at once. It takes effect at once while the counter is stopped, and at the next reload while the counter runs.
- R9: A write that starts or stops the counter drives every enabled output to its pulse level. A control write drives that output to the new setting's pulse level, or to 0 if the new setting is off.
- R10: Control bit 7 is a flag. It is set on an advance of an enabled channel where the counter reaches the effective compare value. Writing 1 to bit 7 clears it, but a match in the same cycle keeps it set. Writing 0 to bit 7 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| pwm_o | output | NUM_CH | Channel outputs, registered |

## Verification
The checker watches the counter on every cycle. It checks that the counter returns to zero after each reload, steps by exactly one on other advances, and holds while stopped. It also checks that a disabled channel never drives a high output and that the parameter register always returns the channel count. The bench scenarios cover the rest:
- the duty shape against the counter for random moduli, compare values and polarities;
- the deferral of modulo and compare writes until the reload;
- the forcing of outputs on start, stop and control writes;
- the set and clear rules of the match flag.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int unsigned OFF_PARAM  = 'h04;
  localparam int unsigned OFF_GLOBAL = 'h08;
  localparam int unsigned OFF_SC     = 'h10;
  localparam int unsigned OFF_CNT    = 'h14;
  localparam int unsigned OFF_MOD    = 'h18;
  localparam int unsigned OFF_CH     = 'h20;
  localparam int unsigned CH_STRIDE  = 8;
  localparam int unsigned CH_VAL_OFS = 4;

  localparam logic [1:0] CLK_RUN = 2'b01;

  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] lvl;
  } ch_cfg_t;

  function automatic logic cfg_on(ch_cfg_t c);
    return (c.mode == 2'b10) && ((c.lvl == 2'b10) || (c.lvl == 2'b01));
  endfunction

  function automatic logic cfg_pulse(ch_cfg_t c);
    return c.lvl == 2'b10;
  endfunction
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int unsigned PS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [PS_W-1:0] ps_i,
  output logic            tick_o
);
  localparam int unsigned DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] lim;

  always_comb begin
    span   = (DIV_W+1)'(1) << ps_i;
    lim    = DIV_W'(span - 1'b1);
    tick_o = !clr_i && (div_q == lim);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                div_q <= '0;
    else if (clr_i || tick_o)   div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             mod_we_i,
  input  logic [CNT_W-1:0] mod_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] mod_act_o,
  output logic [CNT_W-1:0] mod_buf_o,
  output logic [CNT_W-1:0] nxt_cnt_o,
  output logic             reload_o
);
  logic [CNT_W-1:0] cnt_q, mod_act_q, mod_buf_q;

  always_comb begin
    reload_o  = tick_i && (cnt_q >= mod_act_q);
    nxt_cnt_o = reload_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      mod_act_q <= '0;
      mod_buf_q <= '0;
    end else begin
      if (clr_i)       cnt_q <= '0;
      else if (tick_i) cnt_q <= nxt_cnt_o;
      if (mod_we_i) mod_buf_q <= mod_wdata_i;
      // stopped: immediate; running: deferred to reload
      if (mod_we_i && !run_i) mod_act_q <= mod_wdata_i;
      else if (reload_o)      mod_act_q <= mod_buf_q;
    end
  end

  assign cnt_o     = cnt_q;
  assign mod_act_o = mod_act_q;
  assign mod_buf_o = mod_buf_q;
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic             mode_chg_i,
  input  logic [CNT_W-1:0] nxt_cnt_i,
  input  logic             ctl_we_i,
  input  logic             clr_flag_i,
  input  logic [3:0]       cfg_wdata_i,
  input  logic             val_we_i,
  input  logic [CNT_W-1:0] val_wdata_i,
  output logic             pwm_o,
  output logic             en_o,
  output logic [7:0]       ctl_rd_o,
  output logic [CNT_W-1:0] val_rd_o
);
  ch_cfg_t          cfg_q, cfg_new;
  logic             flag_q, out_q, hit;
  logic [CNT_W-1:0] val_buf_q, val_act_q, nxt_val;

  always_comb begin
    cfg_new = ch_cfg_t'(cfg_wdata_i);
    en_o    = cfg_on(cfg_q);
    nxt_val = reload_i ? val_buf_q : val_act_q;
    hit     = tick_i && en_o && (nxt_cnt_i == nxt_val);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      flag_q    <= 1'b0;
      val_buf_q <= '0;
      val_act_q <= '0;
      out_q     <= 1'b0;
    end else begin
      if (ctl_we_i) cfg_q <= cfg_new;
      if (hit)                          flag_q <= 1'b1;
      else if (ctl_we_i && clr_flag_i)  flag_q <= 1'b0;
      if (val_we_i) val_buf_q <= val_wdata_i;
      if (val_we_i && !run_i) val_act_q <= val_wdata_i;
      else if (reload_i)      val_act_q <= val_buf_q;
      // output priority: config write, disable, start/stop, advance
      if (ctl_we_i)
        out_q <= cfg_on(cfg_new) ? cfg_pulse(cfg_new) : 1'b0;
      else if (!en_o)
        out_q <= 1'b0;
      else if (mode_chg_i)
        out_q <= cfg_pulse(cfg_q);
      else if (tick_i)
        out_q <= (nxt_cnt_i < nxt_val) ? cfg_pulse(cfg_q) : !cfg_pulse(cfg_q);
    end
  end

  assign pwm_o    = out_q;
  assign ctl_rd_o = {flag_q, 1'b0, cfg_q, 2'b00};
  assign val_rd_o = val_buf_q;
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PS_W   = 3,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  localparam logic [ADDR_W-1:0] A_PARAM = ADDR_W'(OFF_PARAM);
  localparam logic [ADDR_W-1:0] A_SC    = ADDR_W'(OFF_SC);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(OFF_CNT);
  localparam logic [ADDR_W-1:0] A_MOD   = ADDR_W'(OFF_MOD);
  localparam int unsigned MODE_LSB = PS_W;
  localparam int unsigned CTR_BIT  = PS_W + 2;

  function automatic logic [ADDR_W-1:0] ctl_addr(int unsigned i);
    return ADDR_W'(OFF_CH + i * CH_STRIDE);
  endfunction

  function automatic logic [ADDR_W-1:0] val_addr(int unsigned i);
    return ADDR_W'(OFF_CH + i * CH_STRIDE + CH_VAL_OFS);
  endfunction

  logic [PS_W-1:0]  ps_q;
  logic [1:0]       clk_mode_q;
  logic             center_q;
  logic             sc_we, cnt_we_w, mod_we, run_w, new_run, mode_chg_w;
  logic             tick_w, reload_w;
  logic [CNT_W-1:0] cnt_w, mod_act_w, mod_buf_w, nxt_cnt_w;
  logic [NUM_CH-1:0] ch_en_w;
  logic [7:0]       ctl_rd [NUM_CH];
  logic [CNT_W-1:0] val_rd [NUM_CH];
  logic             unused_bits;

  assign unused_bits = ^wdata_i[31:CNT_W];

  always_comb begin
    sc_we      = we_i && (addr_i == A_SC);
    cnt_we_w   = we_i && (addr_i == A_CNT);
    mod_we     = we_i && (addr_i == A_MOD);
    run_w      = (clk_mode_q == CLK_RUN);
    new_run    = (wdata_i[MODE_LSB+1:MODE_LSB] == CLK_RUN);
    mode_chg_w = sc_we && (new_run != run_w);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q       <= '0;
      clk_mode_q <= '0;
      center_q   <= 1'b0;
    end else if (sc_we) begin
      ps_q       <= wdata_i[PS_W-1:0];
      clk_mode_q <= wdata_i[MODE_LSB+1:MODE_LSB];
      center_q   <= wdata_i[CTR_BIT];
    end
  end

  pwm_prescale #(.PS_W(PS_W)) i_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_we_w || !run_w),
    .ps_i   (ps_q),
    .tick_o (tick_w)
  );

  pwm_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_w),
    .tick_i      (tick_w),
    .clr_i       (cnt_we_w),
    .mod_we_i    (mod_we),
    .mod_wdata_i (wdata_i[CNT_W-1:0]),
    .cnt_o       (cnt_w),
    .mod_act_o   (mod_act_w),
    .mod_buf_o   (mod_buf_w),
    .nxt_cnt_o   (nxt_cnt_w),
    .reload_o    (reload_w)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_channel #(.CNT_W(CNT_W)) i_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (run_w),
      .tick_i      (tick_w),
      .reload_i    (reload_w),
      .mode_chg_i  (mode_chg_w),
      .nxt_cnt_i   (nxt_cnt_w),
      .ctl_we_i    (we_i && (addr_i == ctl_addr(g))),
      .clr_flag_i  (wdata_i[7]),
      .cfg_wdata_i (wdata_i[5:2]),
      .val_we_i    (we_i && (addr_i == val_addr(g))),
      .val_wdata_i (wdata_i[CNT_W-1:0]),
      .pwm_o       (pwm_o[g]),
      .en_o        (ch_en_w[g]),
      .ctl_rd_o    (ctl_rd[g]),
      .val_rd_o    (val_rd[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_PARAM)    rdata_o[7:0]         = 8'(NUM_CH);
    else if (addr_i == A_SC)  rdata_o[CTR_BIT:0]   = {center_q, clk_mode_q, ps_q};
    else if (addr_i == A_CNT) rdata_o[CNT_W-1:0]   = cnt_w;
    else if (addr_i == A_MOD) rdata_o[CNT_W-1:0]   = mod_buf_w;
    for (int unsigned i = 0; i < NUM_CH; i++) begin
      if (addr_i == ctl_addr(i)) rdata_o[7:0]       = ctl_rd[i];
      if (addr_i == val_addr(i)) rdata_o[CNT_W-1:0] = val_rd[i];
    end
  end
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_w,
  input logic              tick_w,
  input logic              reload_w,
  input logic              cnt_we_w,
  input logic [CNT_W-1:0]  cnt_w,
  input logic [NUM_CH-1:0] ch_en_w,
  input logic [NUM_CH-1:0] pwm_o,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       rdata_o
);
  a_r4_reload_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_w |=> (cnt_w == '0));

  a_r4_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_w && !reload_w) |=> (cnt_w == CNT_W'($past(cnt_w) + 1'b1)));

  a_r3_stopped_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_w && !cnt_we_w) |=> $stable(cnt_w));

  a_r2_param_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(4)) |-> (rdata_o[7:0] == 8'(NUM_CH)));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_off
    a_r6_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ch_en_w[g] |-> !pwm_o[g]);
  end
endmodule

bind pwm_timer pwm_timer_chk #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run_w    (run_w),
  .tick_w   (tick_w),
  .reload_w (reload_w),
  .cnt_we_w (cnt_we_w),
  .cnt_w    (cnt_w),
  .ch_en_w  (ch_en_w),
  .pwm_o    (pwm_o),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o)
);

// File: tb/test_pwm_timer.sv
module test_pwm_timer;
  localparam int NCH = 6;
  localparam logic [7:0] A_PAR = 8'h04, A_GLB = 8'h08, A_SC = 8'h10,
                         A_CNT = 8'h14, A_MOD = 8'h18;
  localparam logic [7:0] HI = 8'h28, LO = 8'h24, RSV = 8'h2C, OFF = 8'h00;

  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] pwm;
  int n_chk = 0, n_bad = 0;

  pwm_timer i_pwm_timer (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; #1;
    d = rdata;
  endtask

  function automatic logic [7:0] ctl_a(int n); return 8'(32 + 8 * n); endfunction
  function automatic logic [7:0] val_a(int n); return 8'(36 + 8 * n); endfunction

  function automatic logic exp_pwm(int c, int v, logic [7:0] ctl);
    logic on, hi;
    on = (ctl[5:4] == 2'b10) && (ctl[3:2] == 2'b10 || ctl[3:2] == 2'b01);
    hi = (ctl[3:2] == 2'b10);
    if (!on) return 1'b0;
    return (c < v) ? hi : !hi;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, prev;
    int mx, bad, m;
    logic seen;
    int vals [NCH];
    logic [7:0] ctls [NCH];
    void'($urandom(32'd4711));

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    check("R1 pwm", 32'(pwm), 0);
    rd(A_SC, d);  check("R1 sc", d, 0);
    rd(A_CNT, d); check("R1 cnt", d, 0);
    rd(A_MOD, d); check("R1 mod", d, 0);
    rd(ctl_a(3), d); check("R1 ctl", d, 0);

    // R2 parameter and global
    rd(A_PAR, d); check("R2 param", d, NCH);
    rd(A_GLB, d); check("R2 global", d, 0);

    // R3 prescale 2 with centre bit set
    wr(A_MOD, 32'hFFFF);
    wr(A_SC, 32'h2A);
    repeat (40) @(posedge clk);
    rd(A_CNT, d); check("R3 prescaled count", d, 10);
    rd(A_SC, d);  check("R3 sc readback", d, 32'h2A);

    // R4 hold while stopped, counter write clears
    wr(A_SC, 32'h0);
    rd(A_CNT, prev);
    repeat (10) @(posedge clk);
    rd(A_CNT, d); check("R4 stopped hold", d, prev);
    wr(A_CNT, 32'h1234);
    rd(A_CNT, d); check("R4 counter write clears", d, 0);

    // R5 modulo immediate when stopped, deferred when running
    wr(A_MOD, 5);
    rd(A_MOD, d); check("R5 mod readback", d, 5);
    wr(A_SC, 32'h08);
    wr(A_MOD, 9);
    rd(A_MOD, d); check("R5 mod readback running", d, 9);
    seen = 1'b0; rd(A_CNT, prev);
    for (int i = 0; i < 8; i++) begin
      rd(A_CNT, d);
      if (prev == 5 && d == 0) seen = 1'b1;
      prev = d;
    end
    check("R5 old modulo until reload", 32'(seen), 1);
    mx = 0;
    for (int i = 0; i < 30; i++) begin
      rd(A_CNT, d);
      if (int'(d) > mx) mx = int'(d);
    end
    check("R5 new modulo after reload", 32'(mx), 9);

    // R9 forcing on config write and on start/stop
    wr(A_SC, 32'h0);
    wr(A_MOD, 10);
    wr(val_a(0), 0);
    wr(val_a(1), 0);
    wr(ctl_a(0), HI);
    rd(A_CNT, d); check("R9 ctl write forces high-true pulse", 32'(pwm[0]), 1);
    wr(ctl_a(1), LO);
    rd(A_CNT, d); check("R9 ctl write forces low-true pulse", 32'(pwm[1]), 0);
    wr(A_SC, 32'h0B);
    rd(A_CNT, d);
    check("R9 start forces ch0", 32'(pwm[0]), 1);
    check("R9 start forces ch1", 32'(pwm[1]), 0);
    repeat (20) @(posedge clk);
    rd(A_CNT, d);
    check("R7 zero compare ch0 inactive", 32'(pwm[0]), 0);
    check("R7 zero compare ch1 inactive", 32'(pwm[1]), 1);
    wr(A_SC, 32'h0);
    rd(A_CNT, d);
    check("R9 stop forces ch0", 32'(pwm[0]), 1);
    check("R9 stop forces ch1", 32'(pwm[1]), 0);

    // R10 flag
    wr(A_CNT, 0);
    wr(val_a(0), 4);
    wr(val_a(1), 50);
    wr(ctl_a(1), HI);
    wr(ctl_a(0), HI | 8'h80);
    wr(A_SC, 32'h08);
    repeat (40) @(posedge clk);
    wr(A_SC, 32'h0);
    rd(ctl_a(0), d); check("R10 flag set on match", d, 32'hA8);
    rd(ctl_a(1), d); check("R10 no flag past modulo", d, 32'h28);
    wr(ctl_a(0), HI);
    rd(ctl_a(0), d); check("R10 write 0 keeps flag", d, 32'hA8);
    wr(ctl_a(0), HI | 8'h80);
    rd(ctl_a(0), d); check("R10 write 1 clears flag", d, 32'h28);

    // R8 compare deferred while running
    wr(A_MOD, 20);
    wr(A_CNT, 0);
    wr(val_a(0), 5);
    wr(A_SC, 32'h09);
    for (int i = 0; i < 100; i++) begin
      rd(A_CNT, prev);
      if (prev == 3) break;
    end
    wr(val_a(0), 15);
    rd(val_a(0), d); check("R8 value readback", d, 15);
    seen = 1'b0; bad = 0;
    for (int i = 0; i < 60; i++) begin
      rd(A_CNT, d);
      if (d < prev) seen = 1'b1;
      if (pwm[0] !== exp_pwm(int'(d), seen ? 15 : 5, HI)) bad++;
      prev = d;
    end
    check("R8 old compare until reload", 32'(bad), 0);
    check("R8 reload observed", 32'(seen), 1);

    // R6 R7 R8 random configurations against the counter
    for (int it = 0; it < 20; it++) begin
      wr(A_SC, 32'h0);
      m = 1 + int'($urandom % 40);
      wr(A_MOD, 32'(m));
      wr(A_CNT, 0);
      for (int c = 0; c < NCH; c++) begin
        case ($urandom % 4)
          0: ctls[c] = HI;
          1: ctls[c] = LO;
          2: ctls[c] = RSV;
          default: ctls[c] = OFF;
        endcase
        vals[c] = int'($urandom % 32'(m + 3));
      end
      if (it == 0) begin
        vals[0] = 0; vals[1] = m; vals[2] = m + 1; vals[3] = 1;
        ctls[0] = HI; ctls[1] = LO; ctls[2] = HI; ctls[3] = LO; ctls[4] = RSV; ctls[5] = OFF;
      end
      for (int c = 0; c < NCH; c++) begin
        wr(val_a(c), 32'(vals[c]));
        wr(ctl_a(c), 32'(ctls[c]));
      end
      wr(A_SC, 32'h08 | 32'($urandom % 3));
      repeat (5) @(posedge clk);
      for (int s = 0; s < 60; s++) begin
        logic [NCH-1:0] e;
        rd(A_CNT, d);
        for (int c = 0; c < NCH; c++) e[c] = exp_pwm(int'(d), vals[c], ctls[c]);
        check("R7 duty vs counter (R6 off, R8 stopped write)", 32'(pwm), 32'(e));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule